// File: doc/BRIEF.md
# Synchronous Serial Full-Duplex Master

This block drives a clocked serial link as the clock master. Each transfer is one frame of eight bits: while the frame's bits leave on the data output line, the same number of bits arrive on the data input line. The block produces the serial clock itself from the system clock, using a programmable half-period. The serial clock stays high when the link is idle. The output line changes on each falling edge of the serial clock, and the input line is sampled on each rising edge. Both directions carry the most significant bit first.

The processor side has four parts: a write port into a transmit buffer, a receive buffer that can be read at any time, two status flags (transmit buffer empty, receive buffer full), and two single-cycle interrupt pulses. One mode bit selects how the buffers are used.

- **Single buffering.** Every frame ends with the clock parked high. The next frame waits until software has done both of these, in either order: read the received byte, and written a new byte to send.
- **Double buffering.** The transmit byte moves into the shift register when a frame begins. A byte written while that frame is in progress can then follow straight after it. The clock pauses only when there is nothing left to send, or when a finished byte has nowhere to go because the receive buffer is still unread.

Top module: `sync_ser_master`

## Requirements
- R1: After reset, `sclk` is 1, `tx_empty` is 1, `rx_full` is 0 and both interrupt outputs are 0.
- R2: A `tx_wr` pulse while `tx_empty` is 1 stores `tx_data` and clears `tx_empty` on the next cycle. A `tx_wr` while `tx_empty` is 0 is ignored, and the byte already held is the one sent.
- R3: A frame is 8 bits, sent most significant bit first. `sdo` changes only when `sclk` falls, `sdi` is sampled as `sclk` rises, and `sclk` is 1 whenever no frame is running.
- R4: Every low phase and every high phase of `sclk` lasts `cfg_half` system clock cycles. A value of 0 counts as 1. A frame therefore holds `sclk` low for 8 × half-period cycles.
- R5: When a frame ends, `irq_tx` pulses for exactly one cycle. The received byte then enters the receive buffer (`rx_data`), `rx_full` becomes 1, and `irq_rx` pulses for exactly one cycle.
- R6: An `rx_rd` pulse clears `rx_full` on the next cycle, unless a held byte enters the buffer in that same cycle (R10).
- R7: With `cfg_dbuf` = 0, `sclk` stays high after a frame until `rx_rd` and an accepted `tx_wr` have both happened, in either order. The next frame then begins.
- R8: With `cfg_dbuf` = 1, the transmit buffer is moved into the shift register at frame start, so `tx_empty` becomes 1 during the frame. A byte written during the frame is sent in the very next frame, whether or not the receive buffer has been read.
- R9: With `cfg_dbuf` = 1, if the transmit buffer is empty when a frame ends, `sclk` stays high until a byte is written.
- R10: With `cfg_dbuf` = 1, if `rx_full` is still 1 when a frame ends, the new byte is held back. `rx_data` keeps the old byte and `sclk` stays high. On `rx_rd`, the held byte enters the buffer on the next cycle with an `irq_rx` pulse, and frames may then continue.
- R11: The value of `cfg_dbuf` is sampled at frame start. Changing it during a frame affects only later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dbuf | input | 1 | 1 = double buffering, 0 = single buffering |
| cfg_half | input | 8 | Serial clock half-period in system cycles (0 treated as 1) |
| tx_wr | input | 1 | Transmit buffer write strobe |
| tx_data | input | 8 | Byte to transmit |
| tx_empty | output | 1 | Transmit buffer empty flag |
| rx_rd | input | 1 | Receive buffer read strobe |
| rx_data | output | 8 | Receive buffer contents |
| rx_full | output | 1 | Receive buffer full flag |
| irq_tx | output | 1 | One-cycle pulse at the end of each transmitted frame |
| irq_rx | output | 1 | One-cycle pulse when a byte enters the receive buffer |
| sclk | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The checker enforces these rules on every cycle:
- Both interrupts are one cycle wide.
- `sdo` moves only on a falling `sclk`.
- `sclk` is high whenever no frame is running.
- A write clears the empty flag and a read clears the full flag.
- The clock cannot start in any of the three stall cases: single mode with the receive buffer unread, an empty transmit buffer, or a byte held back.

Other behaviours can only be shown by the bench's scenarios:
- the byte values exchanged in both directions;
- the low-phase lengths, including a half-period setting of zero;
- a write being ignored;
- both orders of read and write releasing a single-mode stall;
- back-to-back frames in double mode;
- a held byte being released;
- a mid-frame mode change taking effect only after the frame.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } ssm_state_e;

endpackage

// File: rtl/ssm_divider.sv
module ssm_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_s;

    div_s d, q;
    logic at_end;

    assign at_end = (q.cnt == half - 1'b1);
    assign tick   = run && at_end;

    always_comb begin
        d = q;
        if (!run || at_end) begin
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/ssm_shifter.sv
module ssm_shifter #(
    parameter int FRAME_BITS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] load_word,
    input  logic                  shift_out,
    input  logic                  sample,
    input  logic                  sdi,
    output logic                  sdo,
    output logic [FRAME_BITS-1:0] rx_word
);
    typedef struct packed {
        logic [FRAME_BITS-1:0] tx_sh;
        logic [FRAME_BITS-1:0] rx_sh;
    } sh_s;

    sh_s d, q;

    assign sdo     = q.tx_sh[FRAME_BITS-1];
    assign rx_word = q.rx_sh;

    always_comb begin
        d = q;
        if (load) begin
            d.tx_sh = load_word;
        end else if (shift_out) begin
            d.tx_sh = {q.tx_sh[FRAME_BITS-2:0], 1'b0};
        end
        if (sample) begin
            d.rx_sh = {q.rx_sh[FRAME_BITS-2:0], sdi};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/ssm_buffers.sv
module ssm_buffers #(
    parameter int FRAME_BITS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tx_wr,
    input  logic [FRAME_BITS-1:0] tx_data,
    input  logic                  rx_rd,
    input  logic                  frame_start,
    input  logic                  start_dbuf,
    input  logic                  frame_end,
    input  logic                  end_dbuf,
    input  logic [FRAME_BITS-1:0] rx_word,
    output logic [FRAME_BITS-1:0] tx_buf,
    output logic                  tx_empty,
    output logic [FRAME_BITS-1:0] rx_buf,
    output logic                  rx_full,
    output logic                  pend,
    output logic                  irq_rx
);
    typedef struct packed {
        logic [FRAME_BITS-1:0] tx_buf;
        logic                  tx_empty;
        logic [FRAME_BITS-1:0] rx_buf;
        logic                  rx_full;
        logic                  pend;
        logic                  irq_rx;
    } buf_s;

    buf_s d, q;
    logic full_after_rd;
    logic deliver;

    assign tx_buf   = q.tx_buf;
    assign tx_empty = q.tx_empty;
    assign rx_buf   = q.rx_buf;
    assign rx_full  = q.rx_full;
    assign pend     = q.pend;
    assign irq_rx   = q.irq_rx;

    assign full_after_rd = q.rx_full && !rx_rd;
    assign deliver = (frame_end && (!end_dbuf || !full_after_rd))
                   || (q.pend && !full_after_rd);

    always_comb begin
        d = q;
        d.irq_rx = 1'b0;

        // transmit side
        if (tx_wr && q.tx_empty) begin
            d.tx_buf   = tx_data;
            d.tx_empty = 1'b0;
        end
        if (frame_start && start_dbuf) begin
            d.tx_empty = 1'b1;
        end
        if (frame_end && !end_dbuf) begin
            d.tx_empty = 1'b1;
        end

        // receive side
        d.rx_full = full_after_rd;
        if (deliver) begin
            d.rx_buf  = rx_word;
            d.rx_full = 1'b1;
            d.irq_rx  = 1'b1;
            d.pend    = 1'b0;
        end else if (frame_end && end_dbuf) begin
            d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
            q.tx_empty <= 1'b1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/sync_ser_master.sv
module sync_ser_master
    import ssm_pkg::*;
#(
    parameter int FRAME_BITS = 8,
    parameter int DIV_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_dbuf,
    input  logic [DIV_W-1:0]      cfg_half,
    input  logic                  tx_wr,
    input  logic [FRAME_BITS-1:0] tx_data,
    output logic                  tx_empty,
    input  logic                  rx_rd,
    output logic [FRAME_BITS-1:0] rx_data,
    output logic                  rx_full,
    output logic                  irq_tx,
    output logic                  irq_rx,
    output logic                  sclk,
    output logic                  sdo,
    input  logic                  sdi
);
    localparam int BIT_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

    typedef struct packed {
        ssm_state_e       st;
        logic             sclk;
        logic [BIT_W-1:0] bit_idx;
        logic [DIV_W-1:0] half;
        logic             mode_dbuf;
        logic             irq_tx;
    } ctl_s;

    ctl_s d, q;

    logic                  tick;
    logic                  start;
    logic                  shift;
    logic                  sample;
    logic                  fin;
    logic                  start_ok;
    logic                  busy;
    logic                  pend;
    logic [DIV_W-1:0]      half_eff;
    logic [FRAME_BITS-1:0] tx_buf;
    logic [FRAME_BITS-1:0] rx_word;

    assign half_eff = (cfg_half == '0) ? DIV_W'(1) : cfg_half;
    assign busy     = (q.st != ST_IDLE);
    assign start_ok = !tx_empty && !pend && (cfg_dbuf || !rx_full);
    assign sclk     = q.sclk;
    assign irq_tx   = q.irq_tx;

    always_comb begin
        d        = q;
        d.irq_tx = 1'b0;
        start    = 1'b0;
        shift    = 1'b0;
        sample   = 1'b0;
        fin      = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_ok) begin
                    start       = 1'b1;
                    d.st        = ST_LOW;
                    d.sclk      = 1'b0;
                    d.bit_idx   = '0;
                    d.half      = half_eff;
                    d.mode_dbuf = cfg_dbuf;
                end
            end
            ST_LOW: begin
                if (tick) begin
                    sample = 1'b1;
                    d.sclk = 1'b1;
                    d.st   = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    if (q.bit_idx == LAST_BIT) begin
                        fin      = 1'b1;
                        d.irq_tx = 1'b1;
                        d.st     = ST_IDLE;
                    end else begin
                        shift     = 1'b1;
                        d.bit_idx = q.bit_idx + 1'b1;
                        d.sclk    = 1'b0;
                        d.st      = ST_LOW;
                    end
                end
            end
            default: begin
                d.st   = ST_IDLE;
                d.sclk = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.st        <= ST_IDLE;
            q.sclk      <= 1'b1;
            q.half      <= DIV_W'(1);
        end else begin
            q <= d;
        end
    end

    ssm_divider #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .half  (q.half),
        .tick  (tick)
    );

    ssm_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .load_word (tx_buf),
        .shift_out (shift),
        .sample    (sample),
        .sdi       (sdi),
        .sdo       (sdo),
        .rx_word   (rx_word)
    );

    ssm_buffers #(.FRAME_BITS(FRAME_BITS)) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_wr       (tx_wr),
        .tx_data     (tx_data),
        .rx_rd       (rx_rd),
        .frame_start (start),
        .start_dbuf  (cfg_dbuf),
        .frame_end   (fin),
        .end_dbuf    (q.mode_dbuf),
        .rx_word     (rx_word),
        .tx_buf      (tx_buf),
        .tx_empty    (tx_empty),
        .rx_buf      (rx_data),
        .rx_full     (rx_full),
        .pend        (pend),
        .irq_rx      (irq_rx)
    );
endmodule

// File: rtl/ssm_checker.sv
module ssm_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_dbuf,
    input logic tx_wr,
    input logic tx_empty,
    input logic rx_rd,
    input logic rx_full,
    input logic irq_tx,
    input logic irq_rx,
    input logic sclk,
    input logic sdo,
    input logic busy,
    input logic pend
);
    assert_irq_tx_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |=> !irq_tx);

    assert_irq_rx_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |=> !irq_rx);

    assert_wr_clears_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && tx_empty) |=> !tx_empty);

    assert_rd_clears_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rd |=> (!rx_full || irq_rx));

    assert_sdo_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> $fell(sclk));

    assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk);

    assert_single_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rx_full && !cfg_dbuf) |=> sclk);

    assert_empty_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && tx_empty) |=> sclk);

    assert_hold_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> (sclk && rx_full));
endmodule

bind sync_ser_master ssm_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_dbuf (cfg_dbuf),
    .tx_wr    (tx_wr),
    .tx_empty (tx_empty),
    .rx_rd    (rx_rd),
    .rx_full  (rx_full),
    .irq_tx   (irq_tx),
    .irq_rx   (irq_rx),
    .sclk     (sclk),
    .sdo      (sdo),
    .busy     (busy),
    .pend     (pend)
);

// File: tb/tb_sync_ser_master.sv
module tb_sync_ser_master;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_dbuf = 1'b0;
    logic [7:0] cfg_half = 8'd2;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_empty;
    logic       rx_rd = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full;
    logic       irq_tx;
    logic       irq_rx;
    logic       sclk;
    logic       sdo;
    logic       sdi = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    int fr = 0;
    int sbit = 7;
    logic [7:0] cap = 8'h00;
    logic [7:0] got [0:31];
    int low_cyc = 0;
    int irq_rx_cnt = 0;
    int irq_tx_cnt = 0;

    always #2 clk = ~clk;

    sync_ser_master dut (
        .clk(clk), .rst_n(rst_n), .cfg_dbuf(cfg_dbuf), .cfg_half(cfg_half),
        .tx_wr(tx_wr), .tx_data(tx_data), .tx_empty(tx_empty),
        .rx_rd(rx_rd), .rx_data(rx_data), .rx_full(rx_full),
        .irq_tx(irq_tx), .irq_rx(irq_rx), .sclk(sclk), .sdo(sdo), .sdi(sdi)
    );

    function automatic logic [7:0] slv(input int k);
        return 8'h3C ^ 8'(k * 29);
    endfunction

    // serial partner: drives on falling edge, captures on rising edge
    always @(negedge sclk) begin
        if (rst_n) sdi = slv(fr)[sbit];
    end
    always @(posedge sclk) begin
        if (rst_n) begin
            cap = {cap[6:0], sdo};
            if (sbit == 0) begin
                got[fr & 31] = cap;
                fr = fr + 1;
                sbit = 7;
            end else begin
                sbit = sbit - 1;
            end
        end
    end

    always @(negedge clk) begin
        if (!sclk) low_cyc = low_cyc + 1;
        if (irq_rx) irq_rx_cnt = irq_rx_cnt + 1;
        if (irq_tx) irq_tx_cnt = irq_tx_cnt + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_err = n_err + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        tx_wr = 1'b1;
        tx_data = v;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk);
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic wait_fr(input int target);
        for (int i = 0; i < 20000 && fr < target; i++) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 sclk", sclk, 1);
        check("R1 tx_empty", tx_empty, 1);
        check("R1 rx_full", rx_full, 0);
        check("R1 irqs", {irq_tx, irq_rx}, 0);
    endtask

    task automatic t_single();
        int base = fr;
        int rc = irq_rx_cnt;
        int tc = irq_tx_cnt;
        cfg_dbuf = 1'b0;
        cfg_half = 8'd2;
        low_cyc = 0;
        wr(8'hA5);
        wait_fr(base + 1);
        check("R3 sent byte msb first", got[base & 31], 8'hA5);
        check("R5 rx_data", rx_data, slv(base));
        check("R5 rx_full", rx_full, 1);
        check("R5 irq_rx one pulse", irq_rx_cnt - rc, 1);
        check("R5 irq_tx one pulse", irq_tx_cnt - tc, 1);
        check("R4 low cycles half=2", low_cyc, 16);
        // write without read: no frame (R7); second write ignored (R2)
        wr(8'h5A);
        check("R2 tx_empty cleared", tx_empty, 0);
        wr(8'hFF);
        repeat (20) @(negedge clk);
        check("R7 stalled until read", fr, base + 1);
        check("R7 sclk high", sclk, 1);
        rd();
        check("R6 rx_full cleared", rx_full, 0);
        wait_fr(base + 2);
        check("R2 ignored write kept old byte", got[(base + 1) & 31], 8'h5A);
        // opposite order: read first, then write
        rd();
        repeat (20) @(negedge clk);
        check("R7 stalled until write", fr, base + 2);
        wr(8'h96);
        wait_fr(base + 3);
        check("R7 resumed after read then write", got[(base + 2) & 31], 8'h96);
        check("R5 rx_data second order", rx_data, slv(base + 2));
        rd();
    endtask

    task automatic t_half_zero();
        int base = fr;
        cfg_half = 8'd0;
        low_cyc = 0;
        wr(8'hC3);
        wait_fr(base + 1);
        check("R4 half=0 acts as 1", low_cyc, 8);
        check("R3 byte at half=0", got[base & 31], 8'hC3);
        rd();
    endtask

    task automatic t_dbuf();
        int base = fr;
        int rc;
        cfg_dbuf = 1'b1;
        cfg_half = 8'd1;
        wr(8'h11);
        for (int i = 0; i < 50 && !tx_empty; i++) @(negedge clk);
        check("R8 buffer moved at start", tx_empty, 1);
        wr(8'h22);
        wait_fr(base + 2);
        check("R8 first byte", got[base & 31], 8'h11);
        check("R8 back-to-back without read", got[(base + 1) & 31], 8'h22);
        check("R10 old byte kept", rx_data, slv(base));
        repeat (20) @(negedge clk);
        check("R9 paused on empty buffer", fr, base + 2);
        check("R9 sclk high", sclk, 1);
        wr(8'h33);
        repeat (20) @(negedge clk);
        check("R10 paused while byte held", fr, base + 2);
        rc = irq_rx_cnt;
        rd();
        check("R10 held byte delivered", rx_data, slv(base + 1));
        check("R10 rx_full after release", rx_full, 1);
        @(negedge clk);
        check("R10 irq_rx on release", irq_rx_cnt - rc, 1);
        wait_fr(base + 3);
        check("R10 frames resume", got[(base + 2) & 31], 8'h33);
        rd();
        repeat (3) @(negedge clk);
        check("R10 third byte delivered", rx_data, slv(base + 2));
        rd();
    endtask

    task automatic t_mode_switch();
        int base = fr;
        cfg_dbuf = 1'b0;
        cfg_half = 8'd2;
        wr(8'h4B);
        for (int i = 0; i < 50 && sclk; i++) @(negedge clk);
        cfg_dbuf = 1'b1;
        repeat (2) @(negedge clk);
        check("R11 single-mode frame keeps buffer", tx_empty, 0);
        wait_fr(base + 1);
        check("R11 tx_empty at frame end", tx_empty, 1);
        check("R11 rx_full at frame end", rx_full, 1);
        wr(8'hB4);
        wait_fr(base + 2);
        check("R11 new mode starts without read", got[(base + 1) & 31], 8'hB4);
        rd();
        repeat (3) @(negedge clk);
        rd();
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_single();
        t_half_zero();
        t_dbuf();
        t_mode_switch();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_chk = n_chk + 1;
                n_err = n_err + 1;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule